// File: doc/BRIEF.md
# Debounced Modem Status Watcher

This block watches two slow modem status inputs, clear-to-send and carrier-detect, and reports their confirmed level changes to a controller. A free-running counter on the system clock produces a sample tick, about 8 ms by default. Each input passes through a two-flop synchronizer, and its value is taken only on that tick. A new level replaces the accepted level only when two samples in a row both show it. The tick comes from the system clock, so detection keeps working while the serial transmit and receive clocks are stopped.

Each confirmed change raises an event for that pin, with a valid/ready handshake that carries the new level. When the controller is ready the event lasts a single cycle. If the controller is busy, the event is held until the controller accepts it. An enable input allows events or suppresses them. The accepted levels keep tracking the inputs either way. A read request returns the accepted levels of both inputs together with the present request-to-send output. That output comes up high after reset and changes only when a write command sets it.

Top module: `line_status_monitor`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, `rts_out` is 1 and `chg_valid` is all zero.
- R2: A cycle with `rts_wr` high loads `rts_wr_val` into `rts_out` on the next cycle. In every other cycle `rts_out` keeps its value.
- R3: The first sample tick after reset loads each pin's accepted level from its input and raises no event.
- R4: Sample ticks fall on every TICK_CYCLES-th clock edge after reset release. A new level on a pin is accepted at the second consecutive tick that sees it. The event appears after that tick and never after the first one.
- R5: A level that differs from the accepted level on only one sample, with the next sample back at the accepted level, is discarded. It changes neither the accepted level nor the event outputs.
- R6: An event is raised only when `report_en` is 1 at the accepting tick. With `report_en` at 0 the accepted level still follows the input.
- R7: `chg_level[i]` carries the newly accepted level of pin i. With `chg_ready[i]` high, `chg_valid[i]` is high for exactly one cycle. With `chg_ready[i]` low, `chg_valid[i]` and `chg_level[i]` hold until a cycle in which ready is high.
- R8: A `rd_req` cycle gives `rd_valid` high in the next cycle. In that cycle `rd_in_lvl` holds the accepted levels (bit 0 clear-to-send, bit 1 carrier-detect) and `rd_rts` holds `rts_out`, whatever the value of `report_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the time base for sampling |
| rst_n | input | 1 | Active-low synchronous reset |
| report_en | input | 1 | 1 allows change events, 0 suppresses them |
| mdm_in | input | NUM_IN | Raw modem inputs: bit 0 clear-to-send, bit 1 carrier-detect |
| rts_wr | input | 1 | Write command for the request-to-send output |
| rts_wr_val | input | 1 | Level to write into request-to-send |
| rts_out | output | 1 | Request-to-send output |
| rd_req | input | 1 | Read request for the present levels |
| rd_valid | output | 1 | Read response strobe |
| rd_in_lvl | output | NUM_IN | Accepted input levels in the read response |
| rd_rts | output | 1 | Request-to-send level in the read response |
| chg_valid | output | NUM_IN | Per-pin change event valid |
| chg_level | output | NUM_IN | Per-pin new level carried by the event |
| chg_ready | input | NUM_IN | Per-pin consumer ready |

## Verification
The hardest case to reach from the ports is a single-sample excursion: the input has to change after one tick and change back before the next, so the first edge of a possible change is seen and then dropped. The bench keeps its own count of clock edges since reset release. This tells it exactly where each tick falls, so it can drive inputs just after a tick and pick how many samples see each level. The same count is used to hold an event against a busy consumer across several cycles, and to show that a change accepted while reporting is disabled never turns into a late event.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  // Per-pin confirmation state
  typedef struct packed {
    logic primed;  // first sample already taken
    logic acc;     // accepted level
    logic pend;    // previous sample differed from acc
  } filt_st_t;

  typedef struct packed {
    filt_st_t nxt;
    logic     fire;  // a new level was accepted on this sample
  } filt_res_t;

  function automatic int unsigned cnt_width(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // One sample step of the two-in-a-row confirmation rule
  function automatic filt_res_t filt_step(filt_st_t cur, logic smp);
    filt_res_t r;
    r.nxt  = cur;
    r.fire = 1'b0;
    if (!cur.primed) begin
      r.nxt.primed = 1'b1;
      r.nxt.acc    = smp;
      r.nxt.pend   = 1'b0;
    end else if (smp == cur.acc) begin
      r.nxt.pend = 1'b0;
    end else if (cur.pend) begin
      r.nxt.acc  = smp;
      r.nxt.pend = 1'b0;
      r.fire     = 1'b1;
    end else begin
      r.nxt.pend = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/lsm_tick_gen.sv
module lsm_tick_gen #(
  parameter int unsigned PERIOD = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import lsm_pkg::*;

  localparam int unsigned W = cnt_width(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/lsm_sync.sv
module lsm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/lsm_pin_filter.sv
module lsm_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  input  logic en,
  input  logic ready,
  output logic lvl,
  output logic ev_valid,
  output logic ev_level
);
  import lsm_pkg::*;

  logic      pin_s;
  filt_st_t  st;
  filt_res_t res;

  lsm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin),
    .q    (pin_s)
  );

  assign res = filt_step(st, pin_s);

  always_ff @(posedge clk) begin
    if (!rst_n)    st <= '0;
    else if (tick) st <= res.nxt;
  end

  // Event slot: a new acceptance wins over a completing handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_level <= 1'b0;
    end else if (tick && res.fire && en) begin
      ev_valid <= 1'b1;
      ev_level <= res.nxt.acc;
    end else if (ev_valid && ready) begin
      ev_valid <= 1'b0;
    end
  end

  assign lvl = st.acc;
endmodule

// File: rtl/line_status_monitor.sv
module line_status_monitor #(
  parameter int unsigned NUM_IN      = 2,
  parameter int unsigned TICK_CYCLES = 1000000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              report_en,
  input  logic [NUM_IN-1:0] mdm_in,
  input  logic              rts_wr,
  input  logic              rts_wr_val,
  output logic              rts_out,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [NUM_IN-1:0] rd_in_lvl,
  output logic              rd_rts,
  output logic [NUM_IN-1:0] chg_valid,
  output logic [NUM_IN-1:0] chg_level,
  input  logic [NUM_IN-1:0] chg_ready
);

  logic              sample_tick;
  logic [NUM_IN-1:0] acc_lvl;

  lsm_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sample_tick)
  );

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
      lsm_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sample_tick),
        .pin     (mdm_in[i]),
        .en      (report_en),
        .ready   (chg_ready[i]),
        .lvl     (acc_lvl[i]),
        .ev_valid(chg_valid[i]),
        .ev_level(chg_level[i])
      );
    end
  endgenerate

  // Request-to-send: high from reset, changed only by a write
  always_ff @(posedge clk) begin
    if (!rst_n)      rts_out <= 1'b1;
    else if (rts_wr) rts_out <= rts_wr_val;
  end

  // Read response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_in_lvl <= '0;
      rd_rts    <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_in_lvl <= acc_lvl;
        rd_rts    <= rts_out;
      end
    end
  end
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
  parameter int unsigned NUM_IN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              report_en,
  input logic              sample_tick,
  input logic              rts_wr,
  input logic              rts_wr_val,
  input logic              rts_out,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [NUM_IN-1:0] chg_valid,
  input logic [NUM_IN-1:0] chg_level,
  input logic [NUM_IN-1:0] chg_ready
);

  // R1
  rts_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (rts_out && chg_valid == '0));

  // R2
  rts_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rts_wr |=> rts_out == $past(rts_wr_val));

  // R2
  rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_wr |=> $stable(rts_out));

  // R8
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_pin_chk
      // R4
      event_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_valid[i]) |-> $past(sample_tick));

      // R6
      event_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_valid[i]) |-> $past(report_en));

      // R7
      event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_valid[i] && !chg_ready[i] && !sample_tick) |=>
          (chg_valid[i] && $stable(chg_level[i])));
    end
  endgenerate
endmodule

bind line_status_monitor lsm_checker #(.NUM_IN(NUM_IN)) u_lsm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .report_en  (report_en),
  .sample_tick(sample_tick),
  .rts_wr     (rts_wr),
  .rts_wr_val (rts_wr_val),
  .rts_out    (rts_out),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .chg_valid  (chg_valid),
  .chg_level  (chg_level),
  .chg_ready  (chg_ready)
);

// File: tb/line_status_monitor_test.sv
module line_status_monitor_test;
  localparam int T = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       report_en = 1'b1;
  logic [1:0] mdm_in = 2'b01;
  logic       rts_wr = 1'b0;
  logic       rts_wr_val = 1'b0;
  logic       rts_out;
  logic       rd_req = 1'b0;
  logic       rd_valid;
  logic [1:0] rd_in_lvl;
  logic       rd_rts;
  logic [1:0] chg_valid;
  logic [1:0] chg_level;
  logic [1:0] chg_ready = 2'b11;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int ev_cnt [2];
  logic ev_lvl [2];
  logic [1:0] acc_model;
  bit done = 0;

  // vector: {report_en, carrier-detect, clear-to-send}
  localparam logic [2:0] VEC [8] = '{3'b100, 3'b110, 3'b111, 3'b001,
                                     3'b100, 3'b111, 3'b010, 3'b100};

  always #4 clk = ~clk;

  line_status_monitor #(.NUM_IN(2), .TICK_CYCLES(T), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .report_en(report_en), .mdm_in(mdm_in),
    .rts_wr(rts_wr), .rts_wr_val(rts_wr_val), .rts_out(rts_out),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_in_lvl(rd_in_lvl), .rd_rts(rd_rts),
    .chg_valid(chg_valid), .chg_level(chg_level), .chg_ready(chg_ready)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        if (chg_valid[i] && chg_ready[i]) begin
          ev_cnt[i] = ev_cnt[i] + 1;
          ev_lvl[i] = chg_level[i];
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance to the negedge just after the next sample edge
  task automatic next_sample();
    do @(negedge clk); while ((cyc % T) != 0);
  endtask

  task automatic do_read(string req, logic [1:0] lvl_exp, logic rts_exp);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid == 1'b1, req, "rd_valid", int'(rd_valid), 1);
    chk(rd_in_lvl == lvl_exp, req, "rd_in_lvl", int'(rd_in_lvl), int'(lvl_exp));
    chk(rd_rts == rts_exp, req, "rd_rts", int'(rd_rts), int'(rts_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    ev_cnt[0] = 0; ev_cnt[1] = 0;
    ev_lvl[0] = 1'b0; ev_lvl[1] = 1'b0;
    repeat (5) @(negedge clk);
    // R1 during reset
    chk(rts_out == 1'b1, "R1", "rts_out in reset", int'(rts_out), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rts_out == 1'b1, "R1", "rts_out after reset", int'(rts_out), 1);
    chk(chg_valid == 2'b00, "R1", "chg_valid after reset", int'(chg_valid), 0);

    // R3 priming sample
    next_sample();
    @(negedge clk);
    chk(ev_cnt[0] == 0 && ev_cnt[1] == 0, "R3", "events at priming",
        ev_cnt[0] + ev_cnt[1], 0);
    do_read("R3", 2'b01, 1'b1);
    acc_model = 2'b01;

    // table walk: each vector lasts two samples
    for (int v = 0; v < 8; v++) begin
      int c0, c1;
      logic [1:0] nv;
      next_sample();
      c0 = ev_cnt[0]; c1 = ev_cnt[1];
      nv = VEC[v][1:0];
      report_en = VEC[v][2];
      mdm_in = nv;
      next_sample();
      next_sample();
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        int d, e;
        d = (i == 0) ? ev_cnt[0] - c0 : ev_cnt[1] - c1;
        e = (VEC[v][2] && nv[i] != acc_model[i]) ? 1 : 0;
        chk(d == e, VEC[v][2] ? "R4" : "R6", $sformatf("vec %0d pin %0d events", v, i), d, e);
        if (e == 1)
          chk(ev_lvl[i] == nv[i], "R7", $sformatf("vec %0d pin %0d level", v, i),
              int'(ev_lvl[i]), int'(nv[i]));
      end
      acc_model = nv;
      do_read("R8", acc_model, 1'b1);
    end
    report_en = 1'b1;

    // R4 / R7: no event after first sample, one-cycle pulse after second
    next_sample();
    begin
      int c0;
      c0 = ev_cnt[0];
      mdm_in[0] = ~acc_model[0];
      next_sample();
      @(negedge clk);
      chk(chg_valid[0] == 1'b0 && ev_cnt[0] == c0, "R4", "event after first sample",
          ev_cnt[0] - c0, 0);
      next_sample();
      chk(chg_valid[0] == 1'b1, "R7", "pulse high", int'(chg_valid[0]), 1);
      chk(chg_level[0] == ~acc_model[0], "R7", "pulse level", int'(chg_level[0]),
          int'(~acc_model[0]));
      @(negedge clk);
      chk(chg_valid[0] == 1'b0, "R7", "pulse one cycle", int'(chg_valid[0]), 0);
      chk(ev_cnt[0] == c0 + 1, "R4", "event count", ev_cnt[0] - c0, 1);
      acc_model[0] = ~acc_model[0];
    end

    // R5: single-sample excursion is rejected
    next_sample();
    begin
      int c0;
      c0 = ev_cnt[0];
      mdm_in[0] = ~acc_model[0];
      next_sample();
      mdm_in[0] = acc_model[0];
      next_sample();
      next_sample();
      @(negedge clk);
      chk(ev_cnt[0] == c0 && chg_valid[0] == 1'b0, "R5", "glitch events", ev_cnt[0] - c0, 0);
      do_read("R5", acc_model, 1'b1);
    end

    // R7: held while consumer is busy
    chg_ready[1] = 1'b0;
    next_sample();
    mdm_in[1] = ~acc_model[1];
    next_sample();
    next_sample();
    repeat (6) @(negedge clk);
    chk(chg_valid[1] == 1'b1, "R7", "held valid", int'(chg_valid[1]), 1);
    chk(chg_level[1] == ~acc_model[1], "R7", "held level", int'(chg_level[1]),
        int'(~acc_model[1]));
    chg_ready[1] = 1'b1;
    @(negedge clk);
    chk(chg_valid[1] == 1'b0, "R7", "cleared after ready", int'(chg_valid[1]), 0);
    acc_model[1] = ~acc_model[1];

    // R6: disabled change still updates level, no late event
    report_en = 1'b0;
    next_sample();
    begin
      int c1;
      c1 = ev_cnt[1];
      mdm_in[1] = ~acc_model[1];
      next_sample();
      next_sample();
      acc_model[1] = ~acc_model[1];
      do_read("R6", acc_model, 1'b1);
      report_en = 1'b1;
      next_sample();
      next_sample();
      @(negedge clk);
      chk(ev_cnt[1] == c1 && chg_valid[1] == 1'b0, "R6", "events while disabled",
          ev_cnt[1] - c1, 0);
    end

    // R2: request-to-send writes
    rts_wr = 1'b1; rts_wr_val = 1'b0;
    @(negedge clk);
    rts_wr = 1'b0; rts_wr_val = 1'b1;
    chk(rts_out == 1'b0, "R2", "rts after write 0", int'(rts_out), 0);
    repeat (4) @(negedge clk);
    chk(rts_out == 1'b0, "R2", "rts holds", int'(rts_out), 0);
    do_read("R8", acc_model, 1'b0);
    rts_wr = 1'b1;
    @(negedge clk);
    rts_wr = 1'b0;
    chk(rts_out == 1'b1, "R2", "rts after write 1", int'(rts_out), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule